// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the programmer-visible working registers of a small 16-bit microcontroller core. Four data registers, two address registers and a frame base register are kept in two complete copies (banks), and a bank-select bit in the block's own flag register chooses which copy every access reaches. A user stack pointer, an interrupt stack pointer, a static base register, a 20-bit interrupt table base and the flag register are held once and shared by both banks. A stack-select bit in the flag register decides whether the stack-pointer alias reaches the user or the interrupt pointer.

One write port and one combinational read port are provided. Each access carries a 4-bit register specifier and a 2-bit size code, so the same storage can be reached as bytes (halves of the first two data registers), as 16-bit words, or as 32-bit pairs. Condition and control flags coming back from an execution unit are merged through a separate masked update port. A write becomes visible on the read port in the cycle after the clock edge that stores it.

Top module: `cpu_regfile`

## Requirements
- R1: After reset every register, in both banks, reads 0 and the flag output is 0, so bank 0 and the interrupt stack pointer are selected.
- R2: A word write (size code 1) with specifier 0..6 stores into data register 0..3, address register 0..1 or the frame base of the active bank; specifier 7 is the static base, 9 the user stack pointer, 10 the interrupt stack pointer, 11 the low 16 bits of the table base, 12 the flag register. A word read with the same specifier returns the value from the next cycle on.
- R3: A byte access (size code 0) uses specifier 0 = low byte of data register 0, 1 = its high byte, 2 = low byte of data register 1, 3 = its high byte; a byte write leaves the other byte of that register unchanged, and a byte read returns the byte zero-extended.
- R4: A 32-bit access (size code 2) with specifier 0 pairs data register 2 (bits 31:16) with data register 0 (bits 15:0), specifier 1 pairs data register 3 with data register 1, and specifier 2 pairs address register 1 (upper) with address register 0 (lower).
- R5: With flag bit 4 clear, bank 0 is accessed; with it set, bank 1 is accessed; the contents of the inactive bank are kept unchanged.
- R6: The static base, both stack pointers, the table base and the flag register read the same value whichever bank is selected.
- R7: Word specifier 8 reaches the interrupt stack pointer when flag bit 7 is 0 and the user stack pointer when it is 1.
- R8: A change to flag bit 4 or bit 7 steers accesses only from the next clock cycle; a register write in the same cycle as the flag change uses the old selection.
- R9: The flag word holds C at bit 0, D at bit 1, Z at bit 2, S at bit 3, bank select at bit 4, O at bit 5, interrupt enable at bit 6, stack select at bit 7 and a 3-bit priority level at bits 14:12; bits 8 to 11, 15 and D always read 0, whatever is written.
- R10: The flag update port replaces each flag bit whose mask bit is 1 with the update value; when it coincides with a register-port write to the flag word, the update port wins on the masked bits and the register-port value holds elsewhere.
- R11: The table base is 20 bits; a 32-bit access with specifier 3 writes bits 19:0 and reads them with bits 31:20 as 0, and a word access with specifier 11 touches only bits 15:0.
- R12: Any other specifier for a size, and size code 3, reads 0, and a write with it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register port |
| wr_size | input | 2 | Write size code: 0 byte, 1 word, 2 pair, 3 none |
| wr_sel | input | 4 | Write register specifier |
| wr_data | input | 32 | Write data, right-aligned |
| flg_upd_en | input | 1 | Flag update strobe |
| flg_upd_mask | input | 16 | Flag bits to replace |
| flg_upd_val | input | 16 | Replacement flag values |
| rd_size | input | 2 | Read size code |
| rd_sel | input | 4 | Read register specifier |
| rd_data | output | 32 | Read data, zero-extended |
| flg_q | output | 16 | Current flag word |

## Verification
The hardest situation to reach is a register write that lands in the very cycle the bank-select or stack-select bit flips, because only then does the one-cycle steering delay decide which physical register is hit. The stimulus sets up distinct values in both banks and both stack pointers, then drives a flag update and a register write on the same edge, and afterwards reads both banks back. The random phase adds flag updates on roughly a quarter of the cycles alongside random writes, so that coincident flips recur with every size and specifier.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  // index of each banked register inside one bank
  localparam int unsigned IDX_R0 = 0;
  localparam int unsigned IDX_R1 = 1;
  localparam int unsigned IDX_R2 = 2;
  localparam int unsigned IDX_R3 = 3;
  localparam int unsigned IDX_A0 = 4;
  localparam int unsigned IDX_A1 = 5;
  localparam int unsigned IDX_FB = 6;
  localparam int unsigned NUM_BANKED = 7;

  // word specifiers
  localparam logic [3:0] SPEC_FB   = 4'd6;
  localparam logic [3:0] SPEC_SB   = 4'd7;
  localparam logic [3:0] SPEC_SP   = 4'd8;
  localparam logic [3:0] SPEC_USP  = 4'd9;
  localparam logic [3:0] SPEC_ISP  = 4'd10;
  localparam logic [3:0] SPEC_INTB = 4'd11;
  localparam logic [3:0] SPEC_FLG  = 4'd12;

  // pair specifiers
  localparam logic [3:0] PAIR_R2R0 = 4'd0;
  localparam logic [3:0] PAIR_R3R1 = 4'd1;
  localparam logic [3:0] PAIR_A1A0 = 4'd2;
  localparam logic [3:0] PAIR_INTB = 4'd3;

  // flag bit positions
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_D = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_S = 3;
  localparam int unsigned FLG_B = 4;
  localparam int unsigned FLG_O = 5;
  localparam int unsigned FLG_I = 6;
  localparam int unsigned FLG_U = 7;
  localparam int unsigned FLG_IPL_LO = 12;
  localparam int unsigned FLG_W = 16;
  // bits that can hold a 1 (D excluded on purpose)
  localparam logic [FLG_W-1:0] FLG_KEEP = 16'h70FD;

endpackage

// File: rtl/rf_bank.sv
module rf_bank
  import regfile_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = NUM_BANKED
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [1:0]                be,
  input  logic [NREG-1:0][DW-1:0]   wd,
  output logic [NREG-1:0][DW-1:0]   q
);
  localparam int unsigned HB = DW / 2;

  logic [NREG-1:0][DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    for (int i = 0; i < NREG; i++) begin
      if (we[i]) begin
        if (be[0]) q_nxt[i][HB-1:0]  = wd[i][HB-1:0];
        if (be[1]) q_nxt[i][DW-1:HB] = wd[i][DW-1:HB];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R2
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && be == 2'b11) |=> (q[g] == $past(wd[g])));
    // R3
    low_byte_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && be == 2'b01) |=> (q[g][DW-1:HB] == $past(q[g][DW-1:HB])));
    // R3
    high_byte_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && be == 2'b10) |=> (q[g][HB-1:0] == $past(q[g][HB-1:0])));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> $stable(q[g]));
  end

endmodule

// File: rtl/rf_shared.sv
module rf_shared
  import regfile_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usp_we,
  input  logic              isp_we,
  input  logic              sb_we,
  input  logic              intb_lo_we,
  input  logic              intb_hi_we,
  input  logic              flg_we,
  input  logic [DW-1:0]     wd,
  input  logic [IW-DW-1:0]  wd_intb_hi,
  input  logic              upd_en,
  input  logic [FLG_W-1:0]  upd_mask,
  input  logic [FLG_W-1:0]  upd_val,
  output logic [DW-1:0]     usp,
  output logic [DW-1:0]     isp,
  output logic [DW-1:0]     sb,
  output logic [IW-1:0]     intb,
  output logic [FLG_W-1:0]  flg
);
  logic [DW-1:0]    usp_nxt, isp_nxt, sb_nxt;
  logic [IW-1:0]    intb_nxt;
  logic [FLG_W-1:0] flg_nxt;
  logic [FLG_W-1:0] flg_mid;

  always_comb begin
    usp_nxt  = usp_we ? wd : usp;
    isp_nxt  = isp_we ? wd : isp;
    sb_nxt   = sb_we  ? wd : sb;
    intb_nxt = intb;
    if (intb_lo_we) intb_nxt[DW-1:0]  = wd;
    if (intb_hi_we) intb_nxt[IW-1:DW] = wd_intb_hi;
    flg_mid = flg_we ? wd[FLG_W-1:0] : flg;
    if (upd_en) flg_mid = (flg_mid & ~upd_mask) | (upd_val & upd_mask);
    flg_nxt = flg_mid & FLG_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp  <= '0;
      isp  <= '0;
      sb   <= '0;
      intb <= '0;
      flg  <= '0;
    end else begin
      usp  <= usp_nxt;
      isp  <= isp_nxt;
      sb   <= sb_nxt;
      intb <= intb_nxt;
      flg  <= flg_nxt;
    end
  end

  // R9
  flg_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg & ~FLG_KEEP) == '0);
  // R9
  flg_debug_set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && wd[FLG_D]) |=> !flg[FLG_D]);
  // R10
  flg_upd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_mask[FLG_C]) |=> (flg[FLG_C] == $past(upd_val[FLG_C])));
  // R10
  flg_upd_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_mask[FLG_B]) |=> (flg[FLG_B] == $past(upd_val[FLG_B])));

endmodule

// File: rtl/rf_wdec.sv
module rf_wdec
  import regfile_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = NUM_BANKED
) (
  input  logic                     wr_en,
  input  logic [1:0]               wr_size,
  input  logic [3:0]               wr_sel,
  input  logic [2*DW-1:0]          wr_data,
  input  logic                     u_flag,
  output logic [NREG-1:0]          bk_we,
  output logic [1:0]               bk_be,
  output logic [NREG-1:0][DW-1:0]  bk_wd,
  output logic                     usp_we,
  output logic                     isp_we,
  output logic                     sb_we,
  output logic                     intb_lo_we,
  output logic                     intb_hi_we,
  output logic                     flg_we
);
  localparam int unsigned HB = DW / 2;

  acc_size_e sz;
  assign sz = acc_size_e'(wr_size);

  always_comb begin
    bk_we      = '0;
    bk_be      = 2'b11;
    usp_we     = 1'b0;
    isp_we     = 1'b0;
    sb_we      = 1'b0;
    intb_lo_we = 1'b0;
    intb_hi_we = 1'b0;
    flg_we     = 1'b0;
    for (int i = 0; i < NREG; i++) bk_wd[i] = wr_data[DW-1:0];
    if (wr_en) begin
      unique case (sz)
        SZ_BYTE: begin
          if (wr_sel < 4'd4) begin
            if (wr_sel[1]) begin
              bk_we[IDX_R1] = 1'b1;
              bk_wd[IDX_R1] = {2{wr_data[HB-1:0]}};
            end else begin
              bk_we[IDX_R0] = 1'b1;
              bk_wd[IDX_R0] = {2{wr_data[HB-1:0]}};
            end
            bk_be = wr_sel[0] ? 2'b10 : 2'b01;
          end
        end
        SZ_WORD: begin
          if (wr_sel <= SPEC_FB) bk_we[wr_sel[2:0]] = 1'b1;
          else begin
            unique case (wr_sel)
              SPEC_SB:   sb_we      = 1'b1;
              SPEC_SP:   begin
                usp_we = u_flag;
                isp_we = !u_flag;
              end
              SPEC_USP:  usp_we     = 1'b1;
              SPEC_ISP:  isp_we     = 1'b1;
              SPEC_INTB: intb_lo_we = 1'b1;
              SPEC_FLG:  flg_we     = 1'b1;
              default:   ;
            endcase
          end
        end
        SZ_LONG: begin
          unique case (wr_sel)
            PAIR_R2R0: begin
              bk_we[IDX_R0] = 1'b1;
              bk_we[IDX_R2] = 1'b1;
              bk_wd[IDX_R2] = wr_data[2*DW-1:DW];
            end
            PAIR_R3R1: begin
              bk_we[IDX_R1] = 1'b1;
              bk_we[IDX_R3] = 1'b1;
              bk_wd[IDX_R3] = wr_data[2*DW-1:DW];
            end
            PAIR_A1A0: begin
              bk_we[IDX_A0] = 1'b1;
              bk_we[IDX_A1] = 1'b1;
              bk_wd[IDX_A1] = wr_data[2*DW-1:DW];
            end
            PAIR_INTB: begin
              intb_lo_we = 1'b1;
              intb_hi_we = 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rf_rmux.sv
module rf_rmux
  import regfile_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned IW   = 20,
  parameter int unsigned NREG = NUM_BANKED
) (
  input  logic [1:0]               rd_size,
  input  logic [3:0]               rd_sel,
  input  logic [NREG-1:0][DW-1:0]  bk_q,
  input  logic [DW-1:0]            usp,
  input  logic [DW-1:0]            isp,
  input  logic [DW-1:0]            sb,
  input  logic [IW-1:0]            intb,
  input  logic [FLG_W-1:0]         flg,
  output logic [2*DW-1:0]          rd_data
);
  localparam int unsigned HB = DW / 2;

  acc_size_e  sz;
  logic [DW-1:0] byte_src;
  assign sz       = acc_size_e'(rd_size);
  assign byte_src = rd_sel[1] ? bk_q[IDX_R1] : bk_q[IDX_R0];

  always_comb begin
    rd_data = '0;
    unique case (sz)
      SZ_BYTE: begin
        if (rd_sel < 4'd4)
          rd_data[HB-1:0] = rd_sel[0] ? byte_src[DW-1:HB] : byte_src[HB-1:0];
      end
      SZ_WORD: begin
        if (rd_sel <= SPEC_FB) rd_data[DW-1:0] = bk_q[rd_sel[2:0]];
        else begin
          unique case (rd_sel)
            SPEC_SB:   rd_data[DW-1:0]    = sb;
            SPEC_SP:   rd_data[DW-1:0]    = flg[FLG_U] ? usp : isp;
            SPEC_USP:  rd_data[DW-1:0]    = usp;
            SPEC_ISP:  rd_data[DW-1:0]    = isp;
            SPEC_INTB: rd_data[DW-1:0]    = intb[DW-1:0];
            SPEC_FLG:  rd_data[FLG_W-1:0] = flg;
            default:   ;
          endcase
        end
      end
      SZ_LONG: begin
        unique case (rd_sel)
          PAIR_R2R0: rd_data = {bk_q[IDX_R2], bk_q[IDX_R0]};
          PAIR_R3R1: rd_data = {bk_q[IDX_R3], bk_q[IDX_R1]};
          PAIR_A1A0: rd_data = {bk_q[IDX_A1], bk_q[IDX_A0]};
          PAIR_INTB: rd_data[IW-1:0] = intb;
          default:   ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [3:0]        wr_sel,
  input  logic [2*DW-1:0]   wr_data,
  input  logic              flg_upd_en,
  input  logic [FLG_W-1:0]  flg_upd_mask,
  input  logic [FLG_W-1:0]  flg_upd_val,
  input  logic [1:0]        rd_size,
  input  logic [3:0]        rd_sel,
  output logic [2*DW-1:0]   rd_data,
  output logic [FLG_W-1:0]  flg_q
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned NREG  = NUM_BANKED;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [NREG-1:0]                     bk_we;
  logic [1:0]                          bk_be;
  logic [NREG-1:0][DW-1:0]             bk_wd;
  logic [NBANK-1:0][NREG-1:0][DW-1:0]  bk_q_all;
  logic [NREG-1:0][DW-1:0]             bk_act;
  logic usp_we, isp_we, sb_we, intb_lo_we, intb_hi_we, flg_we;
  logic [DW-1:0]    usp, isp, sb;
  logic [IW-1:0]    intb;
  logic [FLG_W-1:0] flg;
  logic             bsel;

  assign bsel   = flg[FLG_B];
  assign bk_act = bk_q_all[bsel];
  assign flg_q  = flg;

  rf_wdec #(.DW(DW), .NREG(NREG)) u_wdec (
    .wr_en      (wr_en),
    .wr_size    (wr_size),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .u_flag     (flg[FLG_U]),
    .bk_we      (bk_we),
    .bk_be      (bk_be),
    .bk_wd      (bk_wd),
    .usp_we     (usp_we),
    .isp_we     (isp_we),
    .sb_we      (sb_we),
    .intb_lo_we (intb_lo_we),
    .intb_hi_we (intb_hi_we),
    .flg_we     (flg_we)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [NREG-1:0] we_g;
    assign we_g = (bsel == 1'(g)) ? bk_we : '0;

    rf_bank #(.DW(DW), .NREG(NREG)) u_bank (
      .clk   (clk),
      .rst_n (rst_n_i),
      .we    (we_g),
      .be    (bk_be),
      .wd    (bk_wd),
      .q     (bk_q_all[g])
    );

    // R5
    inactive_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
      (bsel != 1'(g)) |=> $stable(bk_q_all[g]));
  end

  rf_shared #(.DW(DW), .IW(IW)) u_shared (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .usp_we     (usp_we),
    .isp_we     (isp_we),
    .sb_we      (sb_we),
    .intb_lo_we (intb_lo_we),
    .intb_hi_we (intb_hi_we),
    .flg_we     (flg_we),
    .wd         (wr_data[DW-1:0]),
    .wd_intb_hi (wr_data[IW-1:DW]),
    .upd_en     (flg_upd_en),
    .upd_mask   (flg_upd_mask),
    .upd_val    (flg_upd_val),
    .usp        (usp),
    .isp        (isp),
    .sb         (sb),
    .intb       (intb),
    .flg        (flg)
  );

  rf_rmux #(.DW(DW), .IW(IW), .NREG(NREG)) u_rmux (
    .rd_size (rd_size),
    .rd_sel  (rd_sel),
    .bk_q    (bk_act),
    .usp     (usp),
    .isp     (isp),
    .sb      (sb),
    .intb    (intb),
    .flg     (flg),
    .rd_data (rd_data)
  );

  // R7
  sp_alias_isp_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && wr_size == 2'd1 && wr_sel == SPEC_SP && !flg[FLG_U])
      |=> (isp == $past(wr_data[DW-1:0]) && $stable(usp)));
  // R7
  sp_alias_usp_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && wr_size == 2'd1 && wr_sel == SPEC_SP && flg[FLG_U])
      |=> (usp == $past(wr_data[DW-1:0]) && $stable(isp)));
  // R11
  intb_word_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && wr_size == 2'd1 && wr_sel == SPEC_INTB) |=> $stable(intb[IW-1:DW]));

endmodule

// File: tb/cpu_regfile_bench.sv
module cpu_regfile_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_size;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic        flg_upd_en;
  logic [15:0] flg_upd_mask;
  logic [15:0] flg_upd_val;
  logic [1:0]  rd_size;
  logic [3:0]  rd_sel;
  logic [31:0] rd_data;
  logic [15:0] flg_q;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model
  logic [15:0] m_bank [0:1][0:6];
  logic [15:0] m_usp, m_isp, m_sb, m_flg;
  logic [19:0] m_intb;

  cpu_regfile u_cpu_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_size(wr_size), .wr_sel(wr_sel), .wr_data(wr_data),
    .flg_upd_en(flg_upd_en), .flg_upd_mask(flg_upd_mask), .flg_upd_val(flg_upd_val),
    .rd_size(rd_size), .rd_sel(rd_sel), .rd_data(rd_data), .flg_q(flg_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [3:0] s, input logic [1:0] z);
    int b;
    logic [15:0] r;
    b = int'(m_flg[4]);
    exp_rd = '0;
    case (z)
      2'd0: if (s < 4'd4) begin
        r = m_bank[b][int'(s[1])];
        exp_rd = s[0] ? {24'd0, r[15:8]} : {24'd0, r[7:0]};
      end
      2'd1: begin
        if (s <= 4'd6) exp_rd = {16'd0, m_bank[b][int'(s)]};
        else case (s)
          4'd7:  exp_rd = {16'd0, m_sb};
          4'd8:  exp_rd = {16'd0, m_flg[7] ? m_usp : m_isp};
          4'd9:  exp_rd = {16'd0, m_usp};
          4'd10: exp_rd = {16'd0, m_isp};
          4'd11: exp_rd = {16'd0, m_intb[15:0]};
          4'd12: exp_rd = {16'd0, m_flg};
          default: exp_rd = '0;
        endcase
      end
      2'd2: case (s)
        4'd0: exp_rd = {m_bank[b][2], m_bank[b][0]};
        4'd1: exp_rd = {m_bank[b][3], m_bank[b][1]};
        4'd2: exp_rd = {m_bank[b][5], m_bank[b][4]};
        4'd3: exp_rd = {12'd0, m_intb};
        default: exp_rd = '0;
      endcase
      default: exp_rd = '0;
    endcase
  endfunction

  task automatic model_apply(input logic en, input logic [3:0] s, input logic [1:0] z,
                             input logic [31:0] d, input logic ue,
                             input logic [15:0] um, input logic [15:0] uv);
    int b;
    logic [15:0] f;
    b = int'(m_flg[4]);
    f = m_flg;
    if (en) begin
      case (z)
        2'd0: if (s < 4'd4) begin
          if (s[0]) m_bank[b][int'(s[1])][15:8] = d[7:0];
          else      m_bank[b][int'(s[1])][7:0]  = d[7:0];
        end
        2'd1: begin
          if (s <= 4'd6) m_bank[b][int'(s)] = d[15:0];
          else case (s)
            4'd7:  m_sb = d[15:0];
            4'd8:  if (m_flg[7]) m_usp = d[15:0]; else m_isp = d[15:0];
            4'd9:  m_usp = d[15:0];
            4'd10: m_isp = d[15:0];
            4'd11: m_intb[15:0] = d[15:0];
            4'd12: f = d[15:0];
            default: ;
          endcase
        end
        2'd2: case (s)
          4'd0: begin m_bank[b][0] = d[15:0]; m_bank[b][2] = d[31:16]; end
          4'd1: begin m_bank[b][1] = d[15:0]; m_bank[b][3] = d[31:16]; end
          4'd2: begin m_bank[b][4] = d[15:0]; m_bank[b][5] = d[31:16]; end
          4'd3: m_intb = d[19:0];
          default: ;
        endcase
        default: ;
      endcase
    end
    if (ue) f = (f & ~um) | (uv & um);
    m_flg = f & 16'h70FD;
  endtask

  // one clock: drive at negedge, update model at the edge, return at next negedge
  task automatic step(input logic en, input logic [3:0] s, input logic [1:0] z,
                      input logic [31:0] d, input logic ue,
                      input logic [15:0] um, input logic [15:0] uv);
    wr_en = en; wr_sel = s; wr_size = z; wr_data = d;
    flg_upd_en = ue; flg_upd_mask = um; flg_upd_val = uv;
    @(posedge clk);
    model_apply(en, s, z, d, ue, um, uv);
    @(negedge clk);
    wr_en = 1'b0; flg_upd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    step(1'b1, s, z, d, 1'b0, 16'h0, 16'h0);
  endtask

  task automatic chk(input logic [3:0] s, input logic [1:0] z, input string tag);
    logic [31:0] e;
    rd_sel = s; rd_size = z;
    #1;
    e = exp_rd(s, z);
    n_chk++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s sel=%0d size=%0d actual=%h expected=%h", tag, s, z, rd_data, e);
    end
  endtask

  task automatic chk_lit(input logic [3:0] s, input logic [1:0] z,
                         input logic [31:0] e, input string tag);
    rd_sel = s; rd_size = z;
    #1;
    n_chk++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s sel=%0d size=%0d actual=%h expected=%h", tag, s, z, rd_data, e);
    end
  endtask

  task automatic chk_flg(input string tag);
    #1;
    n_chk++;
    if (flg_q !== m_flg) begin
      n_fail++;
      $display("FAIL %s flags actual=%h expected=%h", tag, flg_q, m_flg);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int s = 0; s < 13; s++) chk(4'(s), 2'd1, tag);
    for (int s = 0; s < 4; s++) chk(4'(s), 2'd2, tag);
    chk_flg(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++) for (int i = 0; i < 7; i++) m_bank[b][i] = '0;
    m_usp = '0; m_isp = '0; m_sb = '0; m_flg = '0; m_intb = '0;
    wr_en = 0; wr_size = 0; wr_sel = 0; wr_data = 0;
    flg_upd_en = 0; flg_upd_mask = 0; flg_upd_val = 0;
    rd_size = 2'd1; rd_sel = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_all("R1");
    chk_lit(4'd8, 2'd1, 32'h0, "R1");

    // R2 word writes of each register
    for (int s = 0; s < 13; s++) if (s != 8 && s != 12) wr(4'(s), 2'd1, 32'h1000 + 32'(s) * 32'h111);
    chk_all("R2");
    chk_lit(4'd0, 2'd1, 32'h0000_1000, "R2");

    // R3 byte halves
    wr(4'd1, 2'd0, 32'hFFFF_FFAB);
    chk_lit(4'd0, 2'd1, 32'h0000_AB00, "R3");
    wr(4'd2, 2'd0, 32'h0000_00CD);
    chk_lit(4'd1, 2'd1, 32'h0000_11CD, "R3");
    chk_lit(4'd1, 2'd0, 32'h0000_00AB, "R3");
    chk_lit(4'd3, 2'd0, 32'h0000_0011, "R3");

    // R4 pairs
    wr(4'd0, 2'd2, 32'hDEAD_BEEF);
    chk_lit(4'd2, 2'd1, 32'h0000_DEAD, "R4");
    chk_lit(4'd0, 2'd1, 32'h0000_BEEF, "R4");
    wr(4'd2, 2'd2, 32'hA1A1_A0A0);
    chk_lit(4'd5, 2'd1, 32'h0000_A1A1, "R4");
    wr(4'd1, 2'd2, 32'h3333_1111);
    chk(4'd1, 2'd2, "R4");

    // R7 stack alias
    wr(4'd8, 2'd1, 32'h0000_5A5A);
    chk_lit(4'd10, 2'd1, 32'h0000_5A5A, "R7");
    step(1'b0, 4'd0, 2'd0, 32'h0, 1'b1, 16'h0080, 16'h0080);
    chk_lit(4'd8, 2'd1, 32'h0000_1999, "R7");
    wr(4'd8, 2'd1, 32'h0000_C3C3);
    chk_lit(4'd9, 2'd1, 32'h0000_C3C3, "R7");
    chk_lit(4'd10, 2'd1, 32'h0000_5A5A, "R7");

    // R8 flip bank and write R1 in the same cycle: old bank is hit
    step(1'b1, 4'd1, 2'd1, 32'h0000_2222, 1'b1, 16'h0010, 16'h0010);
    chk_lit(4'd1, 2'd1, 32'h0, "R8");
    // R8 flip stack select and write SP in the same cycle: old pointer (user) is hit
    step(1'b1, 4'd8, 2'd1, 32'h0000_7777, 1'b1, 16'h0080, 16'h0000);
    chk_lit(4'd9, 2'd1, 32'h0000_7777, "R8");
    chk_lit(4'd8, 2'd1, 32'h0000_5A5A, "R8");

    // R5 bank 1 separate, R6 shared visible
    chk_all("R5");
    chk_lit(4'd7, 2'd1, 32'h0000_1777, "R6");
    wr(4'd0, 2'd1, 32'h0000_3333);
    wr(4'd7, 2'd1, 32'h0000_0B0B);
    step(1'b0, 4'd0, 2'd0, 32'h0, 1'b1, 16'h0010, 16'h0000);
    chk_lit(4'd1, 2'd1, 32'h0000_2222, "R5");
    chk_lit(4'd7, 2'd1, 32'h0000_0B0B, "R6");
    chk_all("R5");

    // R9 flag layout, D ignored
    wr(4'd12, 2'd1, 32'h0000_FFFF);
    chk_lit(4'd12, 2'd1, 32'h0000_70FD, "R9");
    chk_flg("R9");
    wr(4'd12, 2'd1, 32'h0000_0002);
    chk_lit(4'd12, 2'd1, 32'h0, "R9");

    // R10 update port wins on masked bits
    step(1'b1, 4'd12, 2'd1, 32'h0000_0025, 1'b1, 16'h0001, 16'h0000);
    chk_lit(4'd12, 2'd1, 32'h0000_0024, "R10");
    step(1'b0, 4'd0, 2'd0, 32'h0, 1'b1, 16'h7000, 16'h5000);
    chk_lit(4'd12, 2'd1, 32'h0000_5024, "R10");

    // R11 table base
    wr(4'd3, 2'd2, 32'hFFFF_FFFF);
    chk_lit(4'd3, 2'd2, 32'h000F_FFFF, "R11");
    wr(4'd11, 2'd1, 32'hFFFF_1234);
    chk_lit(4'd3, 2'd2, 32'h000F_1234, "R11");

    // R12 unmapped specifiers and size 3
    wr(4'd13, 2'd1, 32'hFFFF_FFFF);
    wr(4'd15, 2'd1, 32'hFFFF_FFFF);
    wr(4'd4, 2'd2, 32'hFFFF_FFFF);
    wr(4'd0, 2'd3, 32'hFFFF_FFFF);
    wr(4'd5, 2'd0, 32'hFFFF_FFFF);
    chk_all("R12");
    chk_lit(4'd13, 2'd1, 32'h0, "R12");
    chk_lit(4'd6, 2'd0, 32'h0, "R12");
    chk_lit(4'd0, 2'd3, 32'h0, "R12");

    // random phase: mixed sizes, specifiers and flag flips (R2..R12)
    for (int n = 0; n < 600; n++) begin
      logic ue;
      ue = ($urandom % 4) == 0;
      step($urandom % 3 != 0, 4'($urandom), 2'($urandom), $urandom, ue,
           16'($urandom), 16'($urandom));
      chk(4'($urandom), 2'($urandom), "R2");
      chk(4'($urandom % 4), 2'd2, "R4");
      chk_flg("R10");
    end
    chk_all("R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule